// File: doc/BRIEF.md
# Accumulator ALU with flag unit

This block is the arithmetic core of a small accumulator machine. It works on an 8-bit accumulator value and on a 16-bit register-pair value. Each cycle, a caller presents an operation code, the accumulator value, the pair value, a second operand and a bit index. The block then gives back a result, a write strobe for that result and three flags.

The result and its write strobe are combinational, so they are valid in the same cycle as the inputs. The flags zero (Z), auxiliary carry (AC) and carry (CY) live in registers. They change on the clock edge that ends a cycle with `op_valid` high. Each operation updates only its own subset of the flags.

Across the whole project, Z means that the full result width (8 or 16 bits) is zero. CY on a subtraction or compare means a borrow out of the top bit. AC is the carry or borrow between bits 3 and 4; for word operations it comes from the low byte.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, all three flag outputs read 0.
- R2: When `op_valid` is low, `result_we` is 0 and no flag changes at the next edge.
- R3: Op 0 (byte compare) raises no write. It sets Z when `a_in - opnd[7:0]` is zero mod 256, CY when `a_in < opnd[7:0]`, and AC when `a_in[3:0] < opnd[3:0]`.
- R4: Op 1 writes `ax_in + opnd` and op 2 writes `ax_in - opnd`, both mod 65536. Both set Z on a zero result and set CY on carry (op 1) or borrow (op 2). Both set AC from bits 3:0 of the two values.
- R5: Op 3 (word compare) raises no write and sets Z, AC and CY exactly as op 2 would.
- R6: Op 4 writes `a_in + 1` and op 5 writes `a_in - 1`, both 8 bits with `result[15:8]` = 0. Both update Z and AC, and CY keeps its prior value.
- R7: Op 6 writes `ax_in + 1` and op 7 writes `ax_in - 1`, both 16 bits. No flag changes.
- R8: Op 8 writes `a_in` rotated right by one and op 9 writes it rotated left by one. The bit that wraps around is also copied into CY. Z and AC are kept.
- R9: Op 10 writes `{CY, a_in[7:1]}` and takes `a_in[0]` into CY. Op 11 writes `{a_in[6:0], CY}` and takes `a_in[7]` into CY. Z and AC are kept.
- R10: Op 12 sets and op 13 clears bit `bit_idx` of `a_in`, and writes the result. Every other bit and every flag is unchanged.
- R11: Op 14 sets and op 15 clears a bit of the flag word, chosen by `bit_idx`: 6 selects Z, 4 selects AC and 0 selects CY. Any other index changes nothing. Neither op raises a write.
- R12: Op 16 sets CY to 1, op 17 clears CY, and op 18 inverts CY. None of them writes, and all keep Z and AC.
- R13: Op codes 19 to 31 raise no write and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_valid | input | 1 | Qualifies the operation this cycle |
| op_sel | input | 5 | Operation code |
| a_in | input | 8 | Accumulator operand |
| ax_in | input | 16 | Register-pair operand |
| opnd | input | 16 | Second operand (low byte for byte ops) |
| bit_idx | input | 3 | Bit index for bit set and clear |
| result | output | 16 | Operation result |
| result_we | output | 1 | Result should be written back |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Auxiliary carry flag |
| flag_cy | output | 1 | Carry flag |

## Verification
`result` and `result_we` are due in the same cycle as the inputs that cause them, with no register in between. The bench therefore drives the inputs just after a falling edge and compares the result one nanosecond later, before the rising edge. The flags pass through a single register, so they are due one edge later. The bench compares them at the following falling edge against a model that it advances only after that edge.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW    = 8,
  parameter int ZPOS  = 6,
  parameter int ACPOS = 4,
  parameter int CYPOS = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [4:0]             op_sel,
  input  logic [DW-1:0]          a_in,
  input  logic [2*DW-1:0]        ax_in,
  input  logic [2*DW-1:0]        opnd,
  input  logic [$clog2(DW)-1:0]  bit_idx,
  output logic [2*DW-1:0]        result,
  output logic                   result_we,
  output logic                   flag_z,
  output logic                   flag_ac,
  output logic                   flag_cy
);
  localparam int WW = 2 * DW;
  localparam int HB = DW / 2;
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] ZB  = IW'(ZPOS);
  localparam logic [IW-1:0] ACB = IW'(ACPOS);
  localparam logic [IW-1:0] CYB = IW'(CYPOS);

  wire [DW-1:0] b8 = opnd[DW-1:0];

  wire [DW:0] sub8  = {1'b0, a_in} - {1'b0, b8};
  wire [HB:0] subn8 = {1'b0, a_in[HB-1:0]} - {1'b0, b8[HB-1:0]};
  wire [WW:0] add16 = {1'b0, ax_in} + {1'b0, opnd};
  wire [WW:0] sub16 = {1'b0, ax_in} - {1'b0, opnd};
  wire [HB:0] addnw = {1'b0, ax_in[HB-1:0]} + {1'b0, opnd[HB-1:0]};
  wire [HB:0] subnw = {1'b0, ax_in[HB-1:0]} - {1'b0, opnd[HB-1:0]};
  wire [DW-1:0] inc8  = a_in + DW'(1);
  wire [DW-1:0] dec8  = a_in - DW'(1);
  wire [DW-1:0] bmask = DW'(1) << bit_idx;
  wire [DW-1:0] zero8 = '0;

  logic [WW-1:0] res;
  logic          we;
  logic          nz, nac, ncy;

  always_comb begin
    res = '0;
    we  = 1'b0;
    nz  = flag_z;
    nac = flag_ac;
    ncy = flag_cy;
    case (op_sel)
      5'd0: begin
        nz = (sub8[DW-1:0] == zero8); nac = subn8[HB]; ncy = sub8[DW];
      end
      5'd1: begin
        res = add16[WW-1:0]; we = 1'b1;
        nz = (add16[WW-1:0] == '0); nac = addnw[HB]; ncy = add16[WW];
      end
      5'd2, 5'd3: begin
        res = sub16[WW-1:0]; we = (op_sel == 5'd2);
        nz = (sub16[WW-1:0] == '0); nac = subnw[HB]; ncy = sub16[WW];
      end
      5'd4: begin
        res = {zero8, inc8}; we = 1'b1;
        nz = (inc8 == zero8); nac = &a_in[HB-1:0];
      end
      5'd5: begin
        res = {zero8, dec8}; we = 1'b1;
        nz = (dec8 == zero8); nac = ~|a_in[HB-1:0];
      end
      5'd6: begin res = ax_in + WW'(1); we = 1'b1; end
      5'd7: begin res = ax_in - WW'(1); we = 1'b1; end
      5'd8: begin
        res = {zero8, a_in[0], a_in[DW-1:1]}; we = 1'b1; ncy = a_in[0];
      end
      5'd9: begin
        res = {zero8, a_in[DW-2:0], a_in[DW-1]}; we = 1'b1; ncy = a_in[DW-1];
      end
      5'd10: begin
        res = {zero8, flag_cy, a_in[DW-1:1]}; we = 1'b1; ncy = a_in[0];
      end
      5'd11: begin
        res = {zero8, a_in[DW-2:0], flag_cy}; we = 1'b1; ncy = a_in[DW-1];
      end
      5'd12: begin res = {zero8, a_in | bmask};  we = 1'b1; end
      5'd13: begin res = {zero8, a_in & ~bmask}; we = 1'b1; end
      5'd14, 5'd15: begin
        if (bit_idx == ZB)  nz  = (op_sel == 5'd14);
        if (bit_idx == ACB) nac = (op_sel == 5'd14);
        if (bit_idx == CYB) ncy = (op_sel == 5'd14);
      end
      5'd16: ncy = 1'b1;
      5'd17: ncy = 1'b0;
      5'd18: ncy = ~flag_cy;
      default: ;
    endcase
  end

  assign result    = res;
  assign result_we = op_valid & we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z  <= 1'b0;
      flag_ac <= 1'b0;
      flag_cy <= 1'b0;
    end else if (op_valid) begin
      flag_z  <= nz;
      flag_ac <= nac;
      flag_cy <= ncy;
    end
  end
endmodule

module acc_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [4:0]  op_sel,
  input logic [7:0]  a_in,
  input logic [15:0] result,
  input logic        result_we,
  input logic        flag_z,
  input logic        flag_ac,
  input logic        flag_cy
);
  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);
  // R2
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({flag_z, flag_ac, flag_cy}));
  // R3
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 5'd0 || op_sel == 5'd3)) |-> !result_we);
  // R6
  step8_keeps_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 5'd4 || op_sel == 5'd5)) |=> flag_cy == $past(flag_cy));
  // R7
  step16_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_sel == 5'd6 || op_sel == 5'd7)) |=> $stable({flag_z, flag_ac, flag_cy}));
  // R8
  ror_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 5'd8) |-> (result_we && result == {8'h00, a_in[0], a_in[7:1]}));
  // R12
  set_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 5'd16) |=> flag_cy);
  // R12
  clr_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 5'd17) |=> !flag_cy);
  // R13
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel > 5'd18) |=> $stable({flag_z, flag_ac, flag_cy}));
endmodule

bind acc_alu acc_alu_chk u_chk (.*);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [7:0]  a_in = '0;
  logic [15:0] ax_in = '0;
  logic [15:0] opnd = '0;
  logic [2:0]  bit_idx = '0;
  logic [15:0] result;
  logic        result_we;
  logic        flag_z, flag_ac, flag_cy;

  int total = 0;
  int bad = 0;
  int mz = 0, mac = 0, mcy = 0;
  string last_req = "R1";

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .a_in(a_in), .ax_in(ax_in), .opnd(opnd), .bit_idx(bit_idx),
    .result(result), .result_we(result_we),
    .flag_z(flag_z), .flag_ac(flag_ac), .flag_cy(flag_cy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op, input bit v);
    if (!v) return "R2";
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6, 7: return "R7";
      8, 9: return "R8";
      10, 11: return "R9";
      12, 13: return "R10";
      14, 15: return "R11";
      16, 17, 18: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_flags();
    chk(last_req, "flags", {29'd0, flag_z, flag_ac, flag_cy}, (mz << 2) | (mac << 1) | mcy);
  endtask

  task automatic run(input bit v, input int op, input int a, input int ax, input int b, input int bi);
    int er = 0, ewe = 0, nz = mz, nac = mac, ncy = mcy;
    int b8 = b & 255;
    @(negedge clk);
    check_flags();
    op_valid = v; op_sel = 5'(op); a_in = 8'(a); ax_in = 16'(ax);
    opnd = 16'(b); bit_idx = 3'(bi);
    case (op)
      0: begin nz = (((a - b8) & 255) == 0); ncy = (a < b8); nac = ((a % 16) < (b8 % 16)); end
      1: begin er = (ax + b) & 65535; ewe = 1; nz = (er == 0); ncy = (ax + b > 65535);
               nac = ((ax % 16) + (b % 16) > 15); end
      2, 3: begin er = (ax - b) & 65535; ewe = (op == 2); nz = (er == 0); ncy = (ax < b);
                  nac = ((ax % 16) < (b % 16)); end
      4: begin er = (a + 1) & 255; ewe = 1; nz = (er == 0); nac = ((a % 16) == 15); end
      5: begin er = (a - 1) & 255; ewe = 1; nz = (er == 0); nac = ((a % 16) == 0); end
      6: begin er = (ax + 1) & 65535; ewe = 1; end
      7: begin er = (ax - 1) & 65535; ewe = 1; end
      8: begin er = (a >> 1) | ((a & 1) << 7); ewe = 1; ncy = a & 1; end
      9: begin er = ((a << 1) & 255) | (a >> 7); ewe = 1; ncy = a >> 7; end
      10: begin er = (a >> 1) | (mcy << 7); ewe = 1; ncy = a & 1; end
      11: begin er = ((a << 1) & 255) | mcy; ewe = 1; ncy = a >> 7; end
      12: begin er = a | (1 << bi); ewe = 1; end
      13: begin er = a & ~(1 << bi) & 255; ewe = 1; end
      14, 15: begin
        if (bi == 6) nz = (op == 14);
        if (bi == 4) nac = (op == 14);
        if (bi == 0) ncy = (op == 14);
      end
      16: ncy = 1;
      17: ncy = 0;
      18: ncy = 1 - mcy;
      default: ;
    endcase
    #1;
    last_req = req_of(op, v);
    chk(last_req, "result_we", int'(result_we), v ? ewe : 0);
    if (v && ewe != 0) chk(last_req, "result", int'(result), er);
    if (v) begin mz = nz; mac = nac; mcy = ncy; end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk("R1", "flags in reset", {29'd0, flag_z, flag_ac, flag_cy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R3 equal and borrow
    run(1, 0, 8'h5A, 0, 8'h5A, 0);
    run(1, 0, 8'h10, 0, 8'h01, 0);
    run(1, 0, 8'h00, 0, 8'h01, 0);
    // R4 carry wrap and borrow
    run(1, 1, 16'hFFFF, 0, 16'h0001, 0);
    run(1, 2, 0, 16'h0000, 16'h0001, 0);
    run(1, 2, 0, 16'h1234, 16'h1234, 0);
    // R5
    run(1, 3, 0, 16'h0100, 16'h0200, 0);
    // R6 with CY preset
    run(1, 16, 0, 0, 0, 0);
    run(1, 4, 8'hFF, 0, 0, 0);
    run(1, 5, 8'h00, 0, 0, 0);
    run(1, 17, 0, 0, 0, 0);
    run(1, 4, 8'h0F, 0, 0, 0);
    // R7
    run(1, 16, 0, 0, 0, 0);
    run(1, 7, 0, 16'h0000, 0, 0);
    run(1, 6, 0, 16'hFFFF, 0, 0);
    // R8 R9
    run(1, 8, 8'h01, 0, 0, 0);
    run(1, 9, 8'h80, 0, 0, 0);
    run(1, 17, 0, 0, 0, 0);
    run(1, 10, 8'h01, 0, 0, 0);
    run(1, 11, 8'h00, 0, 0, 0);
    // R10
    run(1, 12, 8'h00, 0, 0, 7);
    run(1, 13, 8'hFF, 0, 0, 3);
    // R11
    run(1, 14, 0, 0, 0, 6);
    run(1, 14, 0, 0, 0, 4);
    run(1, 14, 0, 0, 0, 2);
    run(1, 15, 0, 0, 0, 6);
    // R12
    run(1, 18, 0, 0, 0, 0);
    run(1, 18, 0, 0, 0, 0);
    // R13 and R2
    run(1, 25, 8'h33, 16'h4444, 16'h5555, 1);
    run(0, 16, 0, 0, 0, 0);
    run(0, 4, 8'hFF, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      run(($urandom % 8) != 0, $urandom % 32, $urandom % 256, $urandom % 65536,
          $urandom % 65536, $urandom % 8);
    // R1 mid-run reset with flags set
    run(1, 14, 0, 0, 0, 6);
    run(1, 16, 0, 0, 0, 0);
    @(negedge clk);
    check_flags();
    op_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1", "flags after reset", {29'd0, flag_z, flag_ac, flag_cy}, 0);
    mz = 0; mac = 0; mcy = 0; last_req = "R1";
    @(negedge clk);
    rst_n = 1'b1;
    run(1, 8, 8'h02, 0, 0, 0);
    @(negedge clk);
    check_flags();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule